// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a clocked system to an external asynchronous static RAM of 256K words by 16 bits. The memory has active-low select, read-enable, write-strobe and per-byte lane enables. Each accepted request is a single-word read or write. The controller turns it into a strobe sequence that holds the address steady and keeps every strobe low long enough for the memory's access, pulse-width and setup limits. It also leaves the shared data bus undriven until the memory has let go of it.

All wait-state counts come from two parameters: the clock period in nanoseconds and a speed-grade select. The counts are rounded up when the design is elaborated. The user side has a valid/ready handshake and returns read data with a one-clock valid pulse. The memory side has a split data bus (out, in, drive enable) meant for a tri-state pad.

Top module: `asram_port_ctrl`

## Requirements
- R1: During reset and whenever the controller is idle, select, read-enable and write-strobe are high, both lane enables are high, the data drive enable is low, and req_ready is high.
- R2: A read holds select and read-enable low, the write strobe high and both lane enables low for RD_N clocks. RD_N is the access time divided by the clock period, rounded up: 11 at 5 ns in the fast grade. The word present at the end of the last of those clocks appears on rd_data, and rd_valid is high for exactly one clock.
- R3: A write holds select low, read-enable high and the write strobe low for WP_N clocks. WP_N is the largest of pulse width, address-to-end and data setup divided by the period and rounded up, and never less than the cycle time in clocks minus one: 10 at 5 ns in the fast grade. The write ends with the write strobe rising while select is still low.
- R4: During a write, req_bmask bit 0 enables the lower lane (bits 7:0) and bit 1 enables the upper lane (bits 15:8), where 1 means written. A lane whose mask bit is 0 keeps its old content, and a mask of 00 changes nothing.
- R5: The data drive enable rises on the same edge that the write strobe falls. It falls exactly one clock after the write strobe rises, and the write data stays unchanged until then.
- R6: After a read, the controller does not drive the bus until at least TA_N clocks after read-enable has risen. TA_N is the output-off time divided by the period, rounded up: 4 in the fast grade.
- R7: req_ready is low from the edge that accepts a request until the cycle, turnaround included, is complete. A request offered while req_ready is low is ignored.
- R8: A read keeps req_ready low for RD_N+TA_N clocks and a write for WP_N+1 clocks. The slow grade (SLOW_GRADE=1) uses 70 ns access and cycle time, 60 ns address-to-end, 55 ns pulse, 30 ns setup and 25 ns output-off.
- R9: The memory address does not change while select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Byte lanes to write, bit 0 lower |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | One-clock pulse, rd_data valid |
| mem_addr | output | 18 | Memory address |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_rden_n | output | 1 | Memory output enable, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| mem_lane_n | output | 2 | Lane enables, bit 0 lower, active low |
| mem_dq_out | output | 16 | Data toward the pad |
| mem_dq_in | input | 16 | Data from the pad |
| mem_dq_oe | output | 1 | Pad drive enable |

## Verification
The bench uses a behavioural memory that reports a word only once the access time has passed since the strobes fell. It returns a garbage pattern before that, so a capture that comes one clock early shows up as a data mismatch.

The stimulus covers several cases:
- Full-word writes and reads at the lowest, highest and mid-range addresses test the basic path.
- Single-lane and empty-mask writes followed by word reads separate a correct lane decode from a swapped or ignored one.
- Reads followed directly by writes test the bus turnaround against the output-off time.
- A request offered during a busy cycle tests whether the handshake really blocks.
- A random mix of all of these finishes the run.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
// Shared types and elaboration-time helpers for the async SRAM controller.
// Assumes all timing values are whole nanoseconds.
package asram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WRITE,
        PH_WEND
    } phase_t;

    function automatic int unsigned cdiv(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

    function automatic int unsigned umax(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
// Strobe sequencer: steps through idle, read, turnaround, write and
// write-end phases and drives every memory strobe from a register.
// Assumes go is only asserted while ready is high.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_N  = 11,
    parameter int TA_N  = 4,
    parameter int WP_N  = 10,
    parameter int LANES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_write,
    input  logic [LANES-1:0] go_mask,
    output logic             ready,
    output logic             sel_n,
    output logic             rden_n,
    output logic             wr_n,
    output logic             dq_oe,
    output logic [LANES-1:0] lane_n,
    output logic             capture
);

    localparam int CW = $clog2(umax(umax(RD_N, TA_N), WP_N) + 1);

    phase_t        phase, nxt;
    logic [CW-1:0] cnt;

    // Next phase: leave each timed phase when its counter hits the end.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:  if (go) nxt = go_write ? PH_WRITE : PH_READ;
            PH_READ:  if (cnt == CW'(RD_N - 1)) nxt = PH_TURN;
            PH_TURN:  if (cnt == CW'(TA_N - 1)) nxt = PH_IDLE;
            PH_WRITE: if (cnt == CW'(WP_N - 1)) nxt = PH_WEND;
            PH_WEND:  nxt = PH_IDLE;
            default:  nxt = PH_IDLE;
        endcase
    end

    // Read data is sampled at the edge closing the last read clock.
    assign capture = (phase == PH_READ) && (cnt == CW'(RD_N - 1));

    // Phase, counter and registered strobes decoded from the next phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            ready  <= 1'b1;
            sel_n  <= 1'b1;
            rden_n <= 1'b1;
            wr_n   <= 1'b1;
            dq_oe  <= 1'b0;
            lane_n <= '1;
        end else begin
            phase  <= nxt;
            cnt    <= (nxt != phase) ? '0 : cnt + 1'b1;
            ready  <= (nxt == PH_IDLE);
            sel_n  <= !(nxt == PH_READ || nxt == PH_WRITE || nxt == PH_WEND);
            rden_n <= (nxt != PH_READ);
            wr_n   <= (nxt != PH_WRITE);
            dq_oe  <= (nxt == PH_WRITE || nxt == PH_WEND);
            if (phase == PH_IDLE && go)
                lane_n <= go_write ? ~go_mask : '0;
            else if (nxt == PH_IDLE)
                lane_n <= '1;
        end
    end

    // R1
    idle_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (sel_n && rden_n && wr_n && !dq_oe && lane_n == '1));
    // R2
    read_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rden_n |-> (!sel_n && wr_n && !dq_oe && lane_n == '0));
    // R3
    write_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (!sel_n && rden_n && dq_oe));
    // R3
    wr_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (!sel_n && dq_oe));
    // R5
    oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_oe) |-> $fell(wr_n));
    // R5
    oe_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_oe) |-> (wr_n && $past(wr_n) && !$past(sel_n)));

endmodule

// File: rtl/asram_datapath.sv
`timescale 1ns/1ps
// Address, write-data and read-data registers. The address and write data
// are loaded when a request is accepted and held until the next one, so
// they stay stable for the whole strobe interval.
module asram_datapath #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [DATA_W-1:0] go_wdata,
    input  logic              capture,
    input  logic [DATA_W-1:0] dq_in,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    // Load the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr   <= '0;
            dq_out <= '0;
        end else if (go) begin
            addr   <= go_addr;
            dq_out <= go_wdata;
        end
    end

    // Capture the pad data and raise a one-clock valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= capture;
            if (capture) rd_data <= dq_in;
        end
    end

    // R2
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/asram_port_ctrl.sv
`timescale 1ns/1ps
// Top of the async SRAM controller. Derives wait-state counts from the
// clock period and the speed grade, then joins sequencer and datapath.
// Assumes CLK_NS is a whole number of nanoseconds.
module asram_port_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int CLK_NS     = 5,
    parameter bit SLOW_GRADE = 1'b0
) (
    input  logic                 clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [DATA_W/8-1:0] req_bmask,
    output logic [DATA_W-1:0]   rd_data,
    output logic                rd_valid,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic                mem_sel_n,
    output logic                mem_rden_n,
    output logic                mem_wr_n,
    output logic [DATA_W/8-1:0] mem_lane_n,
    output logic [DATA_W-1:0]   mem_dq_out,
    input  logic [DATA_W-1:0]   mem_dq_in,
    output logic                mem_dq_oe
);

    localparam int LANES = DATA_W / 8;

    localparam int T_ACC = SLOW_GRADE ? 70 : 55;
    localparam int T_OEV = SLOW_GRADE ? 35 : 25;
    localparam int T_CYC = SLOW_GRADE ? 70 : 55;
    localparam int T_AEW = SLOW_GRADE ? 60 : 45;
    localparam int T_PLS = SLOW_GRADE ? 55 : 45;
    localparam int T_SET = SLOW_GRADE ? 30 : 25;
    localparam int T_OFF = SLOW_GRADE ? 25 : 20;

    localparam int RD_N = int'(cdiv(umax(umax(T_ACC, T_OEV), T_CYC), CLK_NS));
    localparam int TA_N = int'(umax(cdiv(T_OFF, CLK_NS), 1));
    localparam int WP_N = int'(umax(cdiv(umax(umax(T_PLS, T_AEW), T_SET), CLK_NS),
                                    cdiv(T_CYC, CLK_NS) - 1));
    localparam int GW   = $clog2(TA_N + 1);

    logic go;
    logic capture;

    assign go = req_valid && req_ready;

    asram_seq #(
        .RD_N  (RD_N),
        .TA_N  (TA_N),
        .WP_N  (WP_N),
        .LANES (LANES)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_write (req_write),
        .go_mask  (req_bmask),
        .ready    (req_ready),
        .sel_n    (mem_sel_n),
        .rden_n   (mem_rden_n),
        .wr_n     (mem_wr_n),
        .dq_oe    (mem_dq_oe),
        .lane_n   (mem_lane_n),
        .capture  (capture)
    );

    asram_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_dp (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (go),
        .go_addr  (req_addr),
        .go_wdata (req_wdata),
        .capture  (capture),
        .dq_in    (mem_dq_in),
        .addr     (mem_addr),
        .dq_out   (mem_dq_out),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    // Checker state: clocks since read-enable was last low, saturating.
    logic [GW-1:0] gap;
    always_ff @(posedge clk) begin
        if (!rst_n)          gap <= GW'(TA_N);
        else if (!mem_rden_n) gap <= '0;
        else if (gap != GW'(TA_N)) gap <= gap + 1'b1;
    end

    // R6
    turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> (gap >= GW'(TA_N)));
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_sel_n |=> (mem_sel_n || $stable(mem_addr)));
    // R7
    busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

endmodule

// File: tb/sim_asram_port_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench with a timed behavioural model of the memory.
module sim_asram_port_ctrl;

    localparam real TCK   = 5.0;
    localparam real T_ACC = 55.0;
    localparam real T_PLS = 45.0;
    localparam real T_AEW = 45.0;
    localparam real T_SET = 25.0;
    localparam real T_OFF = 20.0;
    localparam int  RD_N  = 11;   // ceil(55/5)
    localparam int  TA_N  = 4;    // ceil(20/5)
    localparam int  WP_N  = 10;   // max(ceil(45/5), ceil(55/5)-1)
    localparam logic [17:0] POKE_A = 18'h2AAAA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_bmask = '0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic [17:0] mem_addr;
    logic        mem_sel_n, mem_rden_n, mem_wr_n, mem_dq_oe;
    logic [1:0]  mem_lane_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hDEAD;

    always #2.5 clk = ~clk;

    asram_port_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_bmask(req_bmask), .rd_data(rd_data), .rd_valid(rd_valid),
        .mem_addr(mem_addr), .mem_sel_n(mem_sel_n), .mem_rden_n(mem_rden_n),
        .mem_wr_n(mem_wr_n), .mem_lane_n(mem_lane_n), .mem_dq_out(mem_dq_out),
        .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Model storage and the bench's own expectation, kept apart.
    logic [15:0] cells  [int];
    logic [15:0] shadow [int];
    logic [15:0] exp_q[$];
    string       tag_q[$];

    function automatic logic [15:0] cell_rd(input int a);
        return cells.exists(a) ? cells[a] : 16'h0000;
    endfunction
    function automatic logic [15:0] shadow_rd(input int a);
        return shadow.exists(a) ? shadow[a] : 16'h0000;
    endfunction

    // Memory model: snapshot just after each edge, checks timing, drives data.
    real t_rd = 0.0, t_addr = 0.0, t_wr = 0.0, t_data = 0.0;
    real t_drv_end = -1000.0, t_wr_rise = -1000.0;
    logic        p_sel = 1'b1, p_rden = 1'b1, p_wr = 1'b1, p_oe = 1'b0;
    logic [17:0] p_addr = '0;
    logic [15:0] p_dout = '0;
    logic [1:0]  p_lane = 2'b11;
    always @(posedge clk) begin
        real te, el;
        bit  rd_act, p_rd_act, wr_act, p_wr_act;
        logic [15:0] w;
        #0.1;
        te = $realtime - 0.1;
        if (rst_n) begin
            rd_act   = !mem_sel_n && !mem_rden_n && mem_wr_n;
            p_rd_act = !p_sel && !p_rden && p_wr;
            wr_act   = !mem_sel_n && !mem_wr_n;
            p_wr_act = !p_sel && !p_wr;
            if (mem_addr != p_addr) begin
                // R9 address must not move while selected
                if (!mem_sel_n && !p_sel) chk(0, "R9 addr moved", 32'(mem_addr), 32'(p_addr));
                t_addr = te;
            end
            if (rd_act && !p_rd_act) t_rd = te;
            if (!rd_act && p_rd_act) t_drv_end = te;
            if (wr_act && !p_wr_act) t_wr = te;
            if (mem_wr_n && !p_wr) t_wr_rise = te;
            if ((mem_dq_out != p_dout) || (mem_dq_oe && !p_oe)) t_data = te;
            if (!wr_act && p_wr_act) begin
                // R3 write ended: pulse, address-to-end and setup
                chk(te - t_wr >= T_PLS, "R3 write pulse", 32'($rtoi(te - t_wr)), 32'($rtoi(T_PLS)));
                chk(te - t_addr >= T_AEW, "R3 addr to end", 32'($rtoi(te - t_addr)), 32'($rtoi(T_AEW)));
                chk(p_oe && (te - t_data >= T_SET), "R3 data setup", 32'($rtoi(te - t_data)), 32'($rtoi(T_SET)));
                chk(!mem_sel_n && mem_wr_n, "R3 ends on write strobe", 32'({mem_sel_n, mem_wr_n}), 32'b01);
                // R5 data held past the end of write
                chk(mem_dq_oe && mem_dq_out == p_dout, "R5 data hold", 32'(mem_dq_out), 32'(p_dout));
                w = cell_rd(int'(p_addr));
                if (!p_lane[0]) w[7:0]  = p_dout[7:0];
                if (!p_lane[1]) w[15:8] = p_dout[15:8];
                cells[int'(p_addr)] = w;
            end
            if (mem_dq_oe && !p_oe)
                chk(!mem_wr_n && p_wr, "R5 drive rises with strobe", 32'({p_wr, mem_wr_n}), 32'b10);
            if (!mem_dq_oe && p_oe)
                chk((te - t_wr_rise > TCK - 0.01) && (te - t_wr_rise < TCK + 0.01),
                    "R5 drive falls one clock late", 32'($rtoi(te - t_wr_rise)), 32'($rtoi(TCK)));
            if (mem_dq_oe)
                // R6 no drive while the memory drives or is still turning off
                chk(!rd_act && (te - t_drv_end >= T_OFF), "R6 bus contention",
                    32'($rtoi(te - t_drv_end)), 32'($rtoi(T_OFF)));
            if (rd_act) begin
                el = te + TCK - t_rd;
                if (te + TCK - t_addr < el) el = te + TCK - t_addr;
                mem_dq_in = (el >= T_ACC) ? cell_rd(int'(mem_addr)) : 16'hDEAD;
            end else begin
                mem_dq_in = 16'hDEAD;
            end
            p_sel = mem_sel_n; p_rden = mem_rden_n; p_wr = mem_wr_n; p_oe = mem_dq_oe;
            p_addr = mem_addr; p_dout = mem_dq_out; p_lane = mem_lane_n;
        end
    end

    // Monitor: pop expected read data as rd_valid pulses appear.
    logic prev_rv = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_valid && prev_rv) chk(0, "R2 valid longer than one clock", 32'd2, 32'd1);
            if (rd_valid) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R2 unexpected read data", 32'(rd_data), 32'hFFFFFFFF);
                end else begin
                    logic [15:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    chk(rd_data == e, t, 32'(rd_data), 32'(e));
                end
            end
            prev_rv <= rd_valid;
        end
    end

    // Driver: offers one request, records expectations, times the busy window.
    task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] m, input bit poke, input string tag);
        int busy;
        logic [15:0] w;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_bmask = m;
        if (wr) begin
            w = shadow_rd(int'(a));
            if (m[0]) w[7:0]  = d[7:0];
            if (m[1]) w[15:8] = d[15:8];
            shadow[int'(a)] = w;
        end else begin
            exp_q.push_back(shadow_rd(int'(a)));
            tag_q.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R7 ready drops on accept", 32'(req_ready), 32'd0);
        busy = 0;
        while (!req_ready) begin
            busy++;
            if (poke && busy == 3) begin
                req_valid = 1'b1; req_write = 1'b1; req_addr = POKE_A;
                req_wdata = 16'hFFFF; req_bmask = 2'b11;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R8 busy window length
        chk(busy == (wr ? WP_N + 1 : RD_N + TA_N), "R8 busy clocks", 32'(busy),
            32'(wr ? WP_N + 1 : RD_N + TA_N));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state held during reset
        chk(mem_sel_n && mem_rden_n && mem_wr_n && !mem_dq_oe && mem_lane_n == 2'b11,
            "R1 reset strobes", 32'({mem_sel_n, mem_rden_n, mem_wr_n, mem_dq_oe, mem_lane_n}), 32'b111011);
        chk(req_ready && !rd_valid, "R1 reset handshake", 32'({req_ready, rd_valid}), 32'b10);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(mem_sel_n && !mem_dq_oe && req_ready, "R1 idle after reset",
            32'({mem_sel_n, mem_dq_oe, req_ready}), 32'b101);

        do_req(1, 18'd5, 16'h1234, 2'b11, 0, "W");
        do_req(0, 18'd5, 16'h0, 2'b00, 0, "R2 word read");
        do_req(1, 18'd5, 16'hABCD, 2'b01, 0, "W");
        do_req(0, 18'd5, 16'h0, 2'b00, 0, "R4 lower lane only");
        do_req(1, 18'd5, 16'h77EE, 2'b10, 0, "W");
        do_req(0, 18'd5, 16'h0, 2'b00, 0, "R4 upper lane only");
        do_req(1, 18'd5, 16'h0F0F, 2'b00, 0, "W");
        do_req(0, 18'd5, 16'h0, 2'b00, 0, "R4 empty mask no change");
        do_req(1, 18'h00000, 16'hC001, 2'b11, 0, "W");
        do_req(1, 18'h3FFFF, 16'hFEED, 2'b11, 0, "W");
        do_req(0, 18'h00000, 16'h0, 2'b00, 0, "R2 lowest address");
        do_req(0, 18'h3FFFF, 16'h0, 2'b00, 0, "R2 highest address");
        do_req(0, 18'd5, 16'h0, 2'b00, 1, "R7 read with poke");
        do_req(0, POKE_A, 16'h0, 2'b00, 0, "R7 busy request ignored");
        do_req(1, 18'd5, 16'h5555, 2'b11, 1, "W");
        do_req(0, POKE_A, 16'h0, 2'b00, 0, "R7 busy request ignored in write");
        for (int i = 0; i < 40; i++) begin
            logic [17:0] a;
            a = 18'($urandom_range(0, 15));
            if ($urandom_range(0, 1) == 1)
                do_req(1, a, 16'($urandom), 2'($urandom), 0, "W");
            else
                do_req(0, a, 16'h0, 2'b00, 0, "R2 random read");
        end
        repeat (20) @(negedge clk);
        chk(exp_q.size() == 0, "R2 all reads returned", 32'(exp_q.size()), 32'd0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(100000 * TCK);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule